// File: doc/BRIEF.md
# Dual-Byte Timer with Variable-Width PWM

This block is a 16-bit counting engine that a 2-bit mode input splits or joins in four ways. It can run as two independent 8-bit interval timers, as one 8-bit interval timer beside an 8-bit pulse-width modulator, as a single 16-bit interval timer, or as a pulse-width modulator whose period is a power of two between 2^9 and 2^16 counts. Each interval timer reports through a sticky flag that software clears. The modulator drives one output pin.

Counting advances only on step pulses. In the two split modes the step is the once-per-cycle tick. In the two wide modes a select input can switch the step to the half-cycle tick, which doubles the count rate. The two 8-bit period inputs act as compare values for the timers and as duty values for the modulators. A duty value is copied into a shadow register only when a modulator period starts, so a write made mid-period never cuts a pulse short. There is no data stream through the block. Every pin is a plain level or a one-cycle pulse, with no handshake.

Top module: `tmr_varpwm_top`

## Requirements
- R1: While reset is asserted and in the first cycle after release, pwm_o, lo_flag_o and hi_flag_o are 0, the mode in force is 0 and the counts are 0.
- R2: In modes 0 and 1 the low byte counts steps from 0 up to per_lo_i and then returns to 0. Each return sets lo_flag_o, so the interval is per_lo_i+1 steps.
- R3: In mode 0 the high byte is a second independent timer that counts from 0 up to per_hi_i. Each return to 0 sets hi_flag_o.
- R4: In mode 1 the high byte counts freely through 256 steps. pwm_o is 1 while the high byte is below the latched 8-bit duty and 0 otherwise. Each wrap from 255 to 0 sets hi_flag_o.
- R5: In mode 2 the full 16-bit count runs from 0 up to {per_hi_i, per_lo_i} and then returns to 0. Each return sets hi_flag_o.
- R6: In mode 3 the period is 2^N steps with N = 9 + wsel_i (wsel_i is 3 bits, so N runs from 9 to 16). The count returns to 0 on the step taken at a count of 2^N-1 or above, and each return sets hi_flag_o.
- R7: In mode 3 pwm_o is 1 while the count is below the latched 16-bit duty {per_hi_i, per_lo_i}. A duty of 0 keeps pwm_o at 0 for the whole period, and a duty of 2^N or more keeps it at 1. In modes 0 and 2 pwm_o is 0.
- R8: The duty is latched only on entry to mode 1 or 3 and on each period wrap in that mode. A change to per_hi_i or per_lo_i at any other time does not change pwm_o.
- R9: In modes 0 and 1 a step is a cycle with cyc_tick_i=1. In modes 2 and 3, fine_sel_i=1 makes a step a cycle with half_tick_i=1 instead. Without a step the count holds.
- R10: In mode 3 a step taken while the count equals the latched duty sets lo_flag_o.
- R11: A flag stays 1 until its clear input (clr_lo_i, clr_hi_i) is 1 in a cycle. If the flag's set event falls in the same cycle, the set takes priority and the flag stays 1.
- R12: A change of mode_i takes effect at the next edge. The counts restart at 0, no step is taken in that cycle, and the flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 split timers, 1 timer+PWM, 2 wide timer, 3 variable-width PWM |
| fine_sel_i | input | 1 | In modes 2/3 use half_tick_i as the step |
| cyc_tick_i | input | 1 | Once-per-instruction-cycle step enable |
| half_tick_i | input | 1 | Half-cycle step enable |
| per_lo_i | input | 8 | Low compare / low duty byte |
| per_hi_i | input | 8 | High compare / high duty byte |
| wsel_i | input | 3 | Mode-3 width select, N = 9 + wsel_i |
| clr_lo_i | input | 1 | Clear lo_flag_o |
| clr_hi_i | input | 1 | Clear hi_flag_o |
| pwm_o | output | 1 | Modulator output |
| lo_flag_o | output | 1 | Low-half timer / duty match flag |
| hi_flag_o | output | 1 | High-half / period rollover flag |

## Verification
The step, the mode change and the clears act at the rising edge that samples them. The flags are registered, so they show the result one edge after the triggering input. pwm_o is decoded from the registered count and shadow, so it shows the new count after that same edge. The bench changes inputs only at falling edges. Its model advances exactly once per rising edge, and it compares all three outputs at the next falling edge, half a cycle after the edge that made them. Duty-latch timing, step-source choice and the set-over-clear priority are therefore checked in the exact cycle where they apply.

// File: rtl/tmr_varpwm_pkg.sv
package tmr_varpwm_pkg;
  typedef enum logic [1:0] {
    TM_SPLIT   = 2'd0,
    TM_TMR_PWM = 2'd1,
    TM_WIDE    = 2'd2,
    TM_VARPWM  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_step_mux.sv
module tmr_step_mux
  import tmr_varpwm_pkg::*;
(
  input  tmr_mode_e mode_q,
  input  logic      fine_sel_i,
  input  logic      cyc_tick_i,
  input  logic      half_tick_i,
  output logic      step_o
);
  logic wide_mode;
  // Only the joined modes may run at the half-cycle rate.
  assign wide_mode = (mode_q == TM_WIDE) || (mode_q == TM_VARPWM);
  assign step_o    = (wide_mode && fine_sel_i) ? half_tick_i : cyc_tick_i;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_varpwm_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int WSEL_W   = 3,
  parameter int MIN_BITS = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  tmr_mode_e             mode_q,
  input  logic                  restart,
  input  logic                  step,
  input  logic [BYTE_W-1:0]     per_lo,
  input  logic [BYTE_W-1:0]     per_hi,
  input  logic [WSEL_W-1:0]     wsel,
  input  logic [2*BYTE_W-1:0]   duty_sh,
  output logic [2*BYTE_W-1:0]   cnt,
  output logic                  lo_evt,
  output logic                  hi_evt
);
  localparam int FULL_W = 2 * BYTE_W;

  logic [FULL_W-1:0] cnt_nxt;
  logic [FULL_W:0]   span;
  logic [FULL_W-1:0] top_mask;
  logic [BYTE_W-1:0] lo_b, hi_b;

  assign lo_b = cnt[BYTE_W-1:0];
  assign hi_b = cnt[FULL_W-1:BYTE_W];

  // Terminal count of the variable-width period: 2^N - 1.
  assign span     = (FULL_W+1)'(1) << (MIN_BITS + int'(wsel));
  assign top_mask = span[FULL_W-1:0] - FULL_W'(1);

  always_comb begin
    cnt_nxt = cnt;
    lo_evt  = 1'b0;
    hi_evt  = 1'b0;
    if (restart) begin
      cnt_nxt = '0;
    end else if (step) begin
      unique case (mode_q)
        TM_SPLIT: begin
          if (lo_b == per_lo) begin
            cnt_nxt[BYTE_W-1:0] = '0;
            lo_evt = 1'b1;
          end else begin
            cnt_nxt[BYTE_W-1:0] = lo_b + BYTE_W'(1);
          end
          if (hi_b == per_hi) begin
            cnt_nxt[FULL_W-1:BYTE_W] = '0;
            hi_evt = 1'b1;
          end else begin
            cnt_nxt[FULL_W-1:BYTE_W] = hi_b + BYTE_W'(1);
          end
        end
        TM_TMR_PWM: begin
          if (lo_b == per_lo) begin
            cnt_nxt[BYTE_W-1:0] = '0;
            lo_evt = 1'b1;
          end else begin
            cnt_nxt[BYTE_W-1:0] = lo_b + BYTE_W'(1);
          end
          cnt_nxt[FULL_W-1:BYTE_W] = hi_b + BYTE_W'(1);
          hi_evt = (hi_b == {BYTE_W{1'b1}});
        end
        TM_WIDE: begin
          if (cnt == {per_hi, per_lo}) begin
            cnt_nxt = '0;
            hi_evt  = 1'b1;
          end else begin
            cnt_nxt = cnt + FULL_W'(1);
          end
        end
        TM_VARPWM: begin
          lo_evt = (cnt == duty_sh);
          // >= keeps the count bounded after the width is narrowed.
          if (cnt >= top_mask) begin
            cnt_nxt = '0;
            hi_evt  = 1'b1;
          end else begin
            cnt_nxt = cnt + FULL_W'(1);
          end
        end
        default: cnt_nxt = cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  a_r12_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  a_r9_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(cnt));

  a_r2_lo_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && step && (mode_q != TM_WIDE) && (mode_q != TM_VARPWM) && (lo_b == per_lo))
      |=> (cnt[BYTE_W-1:0] == '0));

  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && step && (mode_q == TM_VARPWM) && (cnt >= top_mask)) |=> (cnt == '0));
endmodule

// File: rtl/tmr_pwm_unit.sv
module tmr_pwm_unit
  import tmr_varpwm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tmr_mode_e           mode_q,
  input  tmr_mode_e           mode_new,
  input  logic                restart,
  input  logic                wrap,
  input  logic [BYTE_W-1:0]   per_lo,
  input  logic [BYTE_W-1:0]   per_hi,
  input  logic [2*BYTE_W-1:0] cnt,
  output logic [2*BYTE_W-1:0] duty_sh,
  output logic                pwm
);
  localparam int FULL_W = 2 * BYTE_W;

  logic [FULL_W-1:0] load_val;
  tmr_mode_e         load_mode;

  assign load_mode = restart ? mode_new : mode_q;

  always_comb begin
    unique case (load_mode)
      TM_TMR_PWM: load_val = {{BYTE_W{1'b0}}, per_hi};
      TM_VARPWM:  load_val = {per_hi, per_lo};
      default:    load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                duty_sh <= '0;
    else if (restart || wrap)  duty_sh <= load_val;
  end

  always_comb begin
    unique case (mode_q)
      TM_TMR_PWM: pwm = (cnt[FULL_W-1:BYTE_W] < duty_sh[BYTE_W-1:0]);
      TM_VARPWM:  pwm = (cnt < duty_sh);
      default:    pwm = 1'b0;
    endcase
  end

  a_r8_duty_held_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !wrap) |=> $stable(duty_sh));

  a_r7_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == TM_VARPWM) && (duty_sh == '0)) |-> !pwm);

  a_r7_idle_modes_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == TM_SPLIT) || (mode_q == TM_WIDE)) |-> !pwm);
endmodule

// File: rtl/tmr_varpwm_top.sv
module tmr_varpwm_top
  import tmr_varpwm_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int WSEL_W   = 3,
  parameter int MIN_BITS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              fine_sel_i,
  input  logic              cyc_tick_i,
  input  logic              half_tick_i,
  input  logic [BYTE_W-1:0] per_lo_i,
  input  logic [BYTE_W-1:0] per_hi_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic              clr_lo_i,
  input  logic              clr_hi_i,
  output logic              pwm_o,
  output logic              lo_flag_o,
  output logic              hi_flag_o
);
  localparam int FULL_W = 2 * BYTE_W;

  tmr_mode_e         mode_q, mode_new;
  logic              restart, step, lo_evt, hi_evt, wrap;
  logic [FULL_W-1:0] cnt, duty_sh;

  assign mode_new = tmr_mode_e'(mode_i);
  assign restart  = (mode_new != mode_q);
  // Duty reload points: modulator period start.
  assign wrap     = hi_evt && ((mode_q == TM_TMR_PWM) || (mode_q == TM_VARPWM));

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= TM_SPLIT;
    else        mode_q <= mode_new;
  end

  tmr_step_mux u_step (
    .mode_q      (mode_q),
    .fine_sel_i  (fine_sel_i),
    .cyc_tick_i  (cyc_tick_i),
    .half_tick_i (half_tick_i),
    .step_o      (step)
  );

  tmr_count_core #(
    .BYTE_W   (BYTE_W),
    .WSEL_W   (WSEL_W),
    .MIN_BITS (MIN_BITS)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_q  (mode_q),
    .restart (restart),
    .step    (step),
    .per_lo  (per_lo_i),
    .per_hi  (per_hi_i),
    .wsel    (wsel_i),
    .duty_sh (duty_sh),
    .cnt     (cnt),
    .lo_evt  (lo_evt),
    .hi_evt  (hi_evt)
  );

  tmr_pwm_unit #(
    .BYTE_W (BYTE_W)
  ) u_pwm (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .mode_new (mode_new),
    .restart  (restart),
    .wrap     (wrap),
    .per_lo   (per_lo_i),
    .per_hi   (per_hi_i),
    .cnt      (cnt),
    .duty_sh  (duty_sh),
    .pwm      (pwm_o)
  );

  // Sticky flags: the set event outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_flag_o <= 1'b0;
      hi_flag_o <= 1'b0;
    end else begin
      if (lo_evt)        lo_flag_o <= 1'b1;
      else if (clr_lo_i) lo_flag_o <= 1'b0;
      if (hi_evt)        hi_flag_o <= 1'b1;
      else if (clr_hi_i) hi_flag_o <= 1'b0;
    end
  end

  a_r11_lo_set: assert property (@(posedge clk) disable iff (!rst_n)
    lo_evt |=> lo_flag_o);

  a_r11_hi_set: assert property (@(posedge clk) disable iff (!rst_n)
    hi_evt |=> hi_flag_o);

  a_r11_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_flag_o && !clr_lo_i) |=> lo_flag_o);

  a_r11_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_flag_o && !clr_hi_i) |=> hi_flag_o);

  a_r12_flags_kept_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && hi_flag_o && !clr_hi_i) |=> hi_flag_o);
endmodule

// File: tb/tmr_varpwm_tb.sv
module tmr_varpwm_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       fine_sel_i = 1'b0, cyc_tick_i = 1'b0, half_tick_i = 1'b0;
  logic [7:0] per_lo_i = 8'd0, per_hi_i = 8'd0;
  logic [2:0] wsel_i = 3'd0;
  logic       clr_lo_i = 1'b0, clr_hi_i = 1'b0;
  logic       pwm_o, lo_flag_o, hi_flag_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string phase = "";
  int unsigned seed_v;

  logic [1:0]  m_mode;
  logic [15:0] m_cnt, m_sh;
  logic        m_lf, m_hf;

  initial forever #2.5 clk = ~clk;

  tmr_varpwm_top dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .fine_sel_i(fine_sel_i),
    .cyc_tick_i(cyc_tick_i), .half_tick_i(half_tick_i), .per_lo_i(per_lo_i),
    .per_hi_i(per_hi_i), .wsel_i(wsel_i), .clr_lo_i(clr_lo_i), .clr_hi_i(clr_hi_i),
    .pwm_o(pwm_o), .lo_flag_o(lo_flag_o), .hi_flag_o(hi_flag_o));

  function automatic logic exp_pwm();
    if (m_mode == 2'd1) return m_cnt[15:8] < m_sh[7:0];
    if (m_mode == 2'd3) return m_cnt < m_sh;
    return 1'b0;
  endfunction

  function automatic logic [15:0] var_top(input logic [2:0] w);
    logic [16:0] s;
    s = 17'd1 << (9 + w);
    return s[15:0] - 16'd1;
  endfunction

  function automatic string tag_pwm();
    return (m_mode == 2'd3) ? "R7" : "R4";
  endfunction
  function automatic string tag_hi();
    case (m_mode)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction
  function automatic string tag_lo();
    return (m_mode == 2'd3) ? "R10" : "R2";
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t actual=%0b expected=%0b", req, phase, $time, act, exp);
    end
  endtask

  // Reference behaviour for one rising edge, built from the requirements.
  task automatic model_edge();
    logic stp, le, he;
    le = 0; he = 0;
    stp = (m_mode >= 2'd2 && fine_sel_i) ? half_tick_i : cyc_tick_i;
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_sh = 0; m_lf = 0; m_hf = 0;
      return;
    end
    if (mode_i != m_mode) begin
      m_mode = mode_i; m_cnt = 0;
      m_sh = (mode_i == 2'd1) ? {8'h00, per_hi_i} :
             (mode_i == 2'd3) ? {per_hi_i, per_lo_i} : 16'h0;
    end else if (stp) begin
      case (m_mode)
        2'd0, 2'd1: begin
          if (m_cnt[7:0] == per_lo_i) begin m_cnt[7:0] = 0; le = 1; end
          else m_cnt[7:0] = m_cnt[7:0] + 8'd1;
          if (m_mode == 2'd0) begin
            if (m_cnt[15:8] == per_hi_i) begin m_cnt[15:8] = 0; he = 1; end
            else m_cnt[15:8] = m_cnt[15:8] + 8'd1;
          end else begin
            if (m_cnt[15:8] == 8'hFF) begin he = 1; m_sh = {8'h00, per_hi_i}; end
            m_cnt[15:8] = m_cnt[15:8] + 8'd1;
          end
        end
        2'd2: begin
          if (m_cnt == {per_hi_i, per_lo_i}) begin m_cnt = 0; he = 1; end
          else m_cnt = m_cnt + 16'd1;
        end
        default: begin
          le = (m_cnt == m_sh);
          if (m_cnt >= var_top(wsel_i)) begin
            m_cnt = 0; he = 1; m_sh = {per_hi_i, per_lo_i};
          end else m_cnt = m_cnt + 16'd1;
        end
      endcase
    end
    if (le) m_lf = 1; else if (clr_lo_i) m_lf = 0;
    if (he) m_hf = 1; else if (clr_hi_i) m_hf = 0;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(pwm_o, exp_pwm(), tag_pwm());
    check(hi_flag_o, m_hf, tag_hi());
    check(lo_flag_o, m_lf, tag_lo());
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1; n_bad++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    seed_v = $urandom(32'd5117);
    m_mode = 0; m_cnt = 0; m_sh = 0; m_lf = 0; m_hf = 0;
    @(negedge clk);
    phase = "R1 reset";
    run(4);
    check(pwm_o, 1'b0, "R1"); check(lo_flag_o, 1'b0, "R1"); check(hi_flag_o, 1'b0, "R1");
    rst_n = 1'b1;
    run(1);
    check(lo_flag_o, 1'b0, "R1"); check(hi_flag_o, 1'b0, "R1");

    phase = "R2 R3 split timers";
    per_lo_i = 8'd3; per_hi_i = 8'd5; cyc_tick_i = 1'b1;
    run(40);
    phase = "R11 clear";
    clr_lo_i = 1'b1; clr_hi_i = 1'b1; cyc_tick_i = 1'b0;
    run(1);
    check(lo_flag_o, 1'b0, "R11"); check(hi_flag_o, 1'b0, "R11");
    clr_lo_i = 1'b0; clr_hi_i = 1'b0;
    // Set and clear on the same edge: count sits at per_lo after 3 steps.
    cyc_tick_i = 1'b1;
    run(3);
    clr_lo_i = 1'b1;
    run(1);
    check(lo_flag_o, 1'b1, "R11");
    clr_lo_i = 1'b0;

    phase = "R4 timer+pwm";
    mode_i = 2'd1; per_hi_i = 8'd64; per_lo_i = 8'd20;
    run(600);

    phase = "R9 half-cycle steps";
    mode_i = 2'd2; per_hi_i = 8'd0; per_lo_i = 8'd9;
    fine_sel_i = 1'b1; cyc_tick_i = 1'b0; half_tick_i = 1'b1;
    run(2);
    clr_hi_i = 1'b1; run(1); clr_hi_i = 1'b0;
    run(12);
    check(hi_flag_o, 1'b1, "R9");
    fine_sel_i = 1'b0; cyc_tick_i = 1'b1; half_tick_i = 1'b0;
    run(30);

    phase = "R7 zero duty";
    mode_i = 2'd3; wsel_i = 3'd0; per_hi_i = 8'd0; per_lo_i = 8'd0; fine_sel_i = 1'b1;
    half_tick_i = 1'b1;
    run(530);
    phase = "R8 duty change mid period";
    per_hi_i = 8'd2; per_lo_i = 8'd88;   // 600 >= 512: full high once latched
    run(200);
    check(pwm_o, 1'b0, "R8");
    run(900);
    phase = "R7 mid duty";
    per_hi_i = 8'd0; per_lo_i = 8'd100;
    run(1100);
    phase = "R6 wider period";
    wsel_i = 3'd2; per_hi_i = 8'd3;
    run(4200);

    phase = "R12 random modes";
    for (int seg = 0; seg < 40; seg++) begin
      mode_i = 2'($urandom_range(0, 3));
      per_lo_i = 8'($urandom_range(0, 40));
      per_hi_i = 8'($urandom_range(0, 3));
      wsel_i = 3'($urandom_range(0, 1));
      fine_sel_i = 1'($urandom_range(0, 1));
      for (int c = 0; c < 600; c++) begin
        cyc_tick_i  = ($urandom_range(0, 3) != 0);
        half_tick_i = ($urandom_range(0, 4) != 0);
        clr_lo_i    = ($urandom_range(0, 15) == 0);
        clr_hi_i    = ($urandom_range(0, 15) == 0);
        if ($urandom_range(0, 49) == 0) per_lo_i = 8'($urandom_range(0, 255));
        cycle();
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule